// File: doc/BRIEF.md
# Two-Stage Segment and Page Address Translator

This block turns a logical address into a physical memory address in two steps. A request carries a segment selector and a byte offset. The selector picks one descriptor from one of two small descriptor tables: one for segments private to the running process and one for segments shared by all processes. The descriptor gives a base and a length. The offset is checked against that length. If it fits, it is added to the base to form a 16-bit linear address.

The linear address then goes to a paging step that uses 4 KB pages. Its upper four bits select one of sixteen page entries. Each entry holds a present flag and a physical frame number. The frame number replaces the page number, and the 12-bit in-page offset passes through unchanged. Two kinds of fault are reported on a separate code. One is an offset beyond the segment length. The other is a page that is not present. For a page fault, the linear page number is returned so that the fault can be serviced.

Both stages are registered, so one request can be accepted every cycle. Each answer appears two cycles after its request. Descriptors and page entries are loaded through two independent write ports.

Top module: `seg_page_xlat`

## Requirements
- R1: After reset every segment length is 0 and every page entry is absent. Any request made before tables are loaded therefore returns fault code 1. rsp_valid is low out of reset.
- R2: A request sampled with req_valid high at one clock edge produces exactly one response with rsp_valid high after the second following edge. Cycles without a request give rsp_valid low.
- R3: Selector bit 3 picks the table: 0 is the private table and 1 is the shared table. Bits 2:0 pick one of eight descriptors in that table.
- R4: An offset greater than or equal to the descriptor's length gives fault code 1, with rsp_paddr and rsp_fault_vpn both 0. An offset of length minus one is accepted.
- R5: With no fault, the linear address is (base + offset) modulo 2^16. The physical address is {frame of page linear[15:12], linear[11:0]}, 15 bits wide, and the fault code is 0.
- R6: An absent page entry gives fault code 2, rsp_fault_vpn equal to linear[15:12], and rsp_paddr 0.
- R7: A length fault takes priority: the page table is not consulted, and the code is 1 even when the page the sum would hit is absent.
- R8: A table write takes effect at the edge where it is presented. A lookup made at that same edge still sees the old entry. Descriptors are read at the request edge, and page entries one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 4 | Segment selector: bit 3 table choice, bits 2:0 descriptor index |
| req_off | input | 16 | Byte offset within the segment |
| seg_wr_en | input | 1 | Descriptor write strobe |
| seg_wr_idx | input | 4 | Descriptor to write, same layout as req_sel |
| seg_wr_base | input | 16 | New segment base |
| seg_wr_limit | input | 16 | New segment length |
| pg_wr_en | input | 1 | Page entry write strobe |
| pg_wr_vpn | input | 4 | Page entry to write |
| pg_wr_frame | input | 3 | New frame number |
| pg_wr_present | input | 1 | New present flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 15 | Physical address, 0 on any fault |
| rsp_fault | output | 2 | 0 none, 1 segment length, 2 page absent |
| rsp_fault_vpn | output | 4 | Faulting linear page number on code 2, else 0 |

## Verification
Directed requests are made through private and shared descriptors that use the same low index, which shows whether the table-select bit is honoured. Offsets are placed at length minus one and at exactly the length to pin down the comparison edge. A base near the top of the space shows that the sum wraps rather than saturating. A request that exceeds its length while pointing at an absent page separates the two fault priorities. Writes timed on the same edge as a lookup, in each stage, tell old-entry from new-entry reads apart. A random stream of back-to-back requests mixed with writes is then compared each cycle against a behavioural model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_PAGE  = 2'd2
  } fault_e;

endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/xlat_seg_stage.sv
module xlat_seg_stage #(
  parameter int LIN_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W:0]   in_sel,
  input  logic [LIN_W-1:0] in_off,
  input  logic             wr_en,
  input  logic [IDX_W:0]   wr_idx,
  input  logic [LIN_W-1:0] wr_base,
  input  logic [LIN_W-1:0] wr_limit,
  output logic             out_valid,
  output logic [LIN_W-1:0] out_lin,
  output logic             out_lfault
);

  localparam int NSEG  = 2 ** IDX_W;
  localparam int NPART = 2;

  logic [LIN_W-1:0] base_arr  [NPART][NSEG];
  logic [LIN_W-1:0] limit_arr [NPART][NSEG];
  logic [LIN_W-1:0] part_base [NPART];
  logic [LIN_W-1:0] part_limit[NPART];

  // one descriptor table per partition, each with its own read mux
  for (genvar p = 0; p < NPART; p++) begin : g_part
    for (genvar e = 0; e < NSEG; e++) begin : g_desc
      logic             we;
      logic [LIN_W-1:0] base_q;
      logic [LIN_W-1:0] limit_q;

      assign we = wr_en && (wr_idx[IDX_W] == 1'(p)) &&
                  (wr_idx[IDX_W-1:0] == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q  <= '0;
          limit_q <= '0;
        end else if (we) begin
          base_q  <= wr_base;
          limit_q <= wr_limit;
        end
      end

      assign base_arr[p][e]  = base_q;
      assign limit_arr[p][e] = limit_q;
    end

    assign part_base[p]  = base_arr[p][in_sel[IDX_W-1:0]];
    assign part_limit[p] = limit_arr[p][in_sel[IDX_W-1:0]];
  end

  logic [LIN_W-1:0] sel_base;
  logic [LIN_W-1:0] sel_limit;
  logic             valid_d;
  logic             lfault_d;
  logic [LIN_W-1:0] lin_d;
  logic             lin_q_en;
  logic             lfault_q;
  logic [LIN_W-1:0] lin_q;
  logic             valid_q;

  always_comb begin
    sel_base  = part_base[in_sel[IDX_W]];
    sel_limit = part_limit[in_sel[IDX_W]];
    lfault_d  = (in_off >= sel_limit);
    lin_d     = lfault_d ? '0 : LIN_W'(sel_base + in_off);
    valid_d   = in_valid;
    lin_q_en  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q    <= '0;
      lfault_q <= 1'b0;
    end else if (lin_q_en) begin
      lin_q    <= lin_d;
      lfault_q <= lfault_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_lin    = lin_q;
  assign out_lfault = lfault_q;

  // R4: an offset at or past the length is flagged by the stage register
  a_r4_limit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_off >= sel_limit) |=> out_valid && out_lfault && (out_lin == '0));

  // R2: stage one always advances a request
  a_r2_seg_advance: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: rtl/xlat_page_stage.sv
module xlat_page_stage
  import xlat_pkg::*;
#(
  parameter int LIN_W    = 16,
  parameter int PG_OFF_W = 12,
  parameter int FRAME_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LIN_W-1:0]              in_lin,
  input  logic                          in_lfault,
  input  logic                          wr_en,
  input  logic [LIN_W-PG_OFF_W-1:0]     wr_idx,
  input  logic [FRAME_W-1:0]            wr_frame,
  input  logic                          wr_present,
  output logic                          out_valid,
  output logic [FRAME_W+PG_OFF_W-1:0]   out_paddr,
  output logic [1:0]                    out_fault,
  output logic [LIN_W-PG_OFF_W-1:0]     out_fvpn
);

  localparam int VPN_W = LIN_W - PG_OFF_W;
  localparam int NPG   = 2 ** VPN_W;
  localparam int PA_W  = FRAME_W + PG_OFF_W;

  logic               pres_vec [NPG];
  logic [FRAME_W-1:0] frm_arr  [NPG];

  for (genvar g = 0; g < NPG; g++) begin : g_pte
    logic               we;
    logic               pres_q;
    logic [FRAME_W-1:0] frm_q;

    assign we = wr_en && (wr_idx == VPN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q <= 1'b0;
        frm_q  <= '0;
      end else if (we) begin
        pres_q <= wr_present;
        frm_q  <= wr_frame;
      end
    end

    assign pres_vec[g] = pres_q;
    assign frm_arr[g]  = frm_q;
  end

  logic [VPN_W-1:0]    vpn;
  logic [PG_OFF_W-1:0] pofs;
  fault_e              fault_d;
  logic [PA_W-1:0]     paddr_d;
  logic [VPN_W-1:0]    fvpn_d;
  logic                valid_d;
  logic                data_en;

  always_comb begin
    vpn     = in_lin[LIN_W-1:PG_OFF_W];
    pofs    = in_lin[PG_OFF_W-1:0];
    fault_d = FLT_NONE;
    paddr_d = '0;
    fvpn_d  = '0;
    if (in_lfault) begin
      fault_d = FLT_LIMIT;
    end else if (!pres_vec[vpn]) begin
      fault_d = FLT_PAGE;
      fvpn_d  = vpn;
    end else begin
      paddr_d = {frm_arr[vpn], pofs};
    end
    valid_d = in_valid;
    data_en = in_valid;
  end

  logic            valid_q;
  fault_e          fault_q;
  logic [PA_W-1:0] paddr_q;
  logic [VPN_W-1:0] fvpn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
      fvpn_q  <= '0;
    end else if (data_en) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
      fvpn_q  <= fvpn_d;
    end
  end

  assign out_valid = valid_q;
  assign out_paddr = paddr_q;
  assign out_fault = fault_q;
  assign out_fvpn  = fvpn_q;

  // R7: a length fault from stage one is never turned into a page fault
  a_r7_limit_first: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_lfault |=> (out_fault == FLT_LIMIT) && (out_paddr == '0) && (out_fvpn == '0));

  // R5: the in-page offset passes through unchanged on a good translation
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_lfault |=> (out_fault == FLT_PAGE) ||
      (out_paddr[PG_OFF_W-1:0] == $past(in_lin[PG_OFF_W-1:0])));

  // R6: a page fault reports the page and no address
  a_r6_page_fault: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_lfault |=> (out_fault != FLT_PAGE) ||
      ((out_paddr == '0) && (out_fvpn == $past(in_lin[LIN_W-1:PG_OFF_W]))));

endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat #(
  parameter int LIN_W     = 16,
  parameter int SEG_IDX_W = 3,
  parameter int PG_OFF_W  = 12,
  parameter int FRAME_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [SEG_IDX_W:0]            req_sel,
  input  logic [LIN_W-1:0]              req_off,
  input  logic                          seg_wr_en,
  input  logic [SEG_IDX_W:0]            seg_wr_idx,
  input  logic [LIN_W-1:0]              seg_wr_base,
  input  logic [LIN_W-1:0]              seg_wr_limit,
  input  logic                          pg_wr_en,
  input  logic [LIN_W-PG_OFF_W-1:0]     pg_wr_vpn,
  input  logic [FRAME_W-1:0]            pg_wr_frame,
  input  logic                          pg_wr_present,
  output logic                          rsp_valid,
  output logic [FRAME_W+PG_OFF_W-1:0]   rsp_paddr,
  output logic [1:0]                    rsp_fault,
  output logic [LIN_W-PG_OFF_W-1:0]     rsp_fault_vpn
);

  logic             rst_s;
  logic             s1_valid;
  logic [LIN_W-1:0] s1_lin;
  logic             s1_lfault;

  xlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  xlat_seg_stage #(
    .LIN_W (LIN_W),
    .IDX_W (SEG_IDX_W)
  ) u_seg (
    .clk        (clk),
    .rst_n      (rst_s),
    .in_valid   (req_valid),
    .in_sel     (req_sel),
    .in_off     (req_off),
    .wr_en      (seg_wr_en),
    .wr_idx     (seg_wr_idx),
    .wr_base    (seg_wr_base),
    .wr_limit   (seg_wr_limit),
    .out_valid  (s1_valid),
    .out_lin    (s1_lin),
    .out_lfault (s1_lfault)
  );

  xlat_page_stage #(
    .LIN_W    (LIN_W),
    .PG_OFF_W (PG_OFF_W),
    .FRAME_W  (FRAME_W)
  ) u_pg (
    .clk        (clk),
    .rst_n      (rst_s),
    .in_valid   (s1_valid),
    .in_lin     (s1_lin),
    .in_lfault  (s1_lfault),
    .wr_en      (pg_wr_en),
    .wr_idx     (pg_wr_vpn),
    .wr_frame   (pg_wr_frame),
    .wr_present (pg_wr_present),
    .out_valid  (rsp_valid),
    .out_paddr  (rsp_paddr),
    .out_fault  (rsp_fault),
    .out_fvpn   (rsp_fault_vpn)
  );

  // R2: each request yields a response two edges later, and only then
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |=> ##1 rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_s)
    !req_valid |=> ##1 !rsp_valid);

  // R4: a length fault never carries an address
  a_r4_no_addr: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid && (rsp_fault == 2'd1) |-> (rsp_paddr == '0) && (rsp_fault_vpn == '0));

  // code 3 is never produced
  a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |-> (rsp_fault != 2'd3));

endmodule

// File: tb/sim_seg_page_xlat.sv
module sim_seg_page_xlat;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_sel;
  logic [15:0] req_off;
  logic        seg_wr_en;
  logic [3:0]  seg_wr_idx;
  logic [15:0] seg_wr_base;
  logic [15:0] seg_wr_limit;
  logic        pg_wr_en;
  logic [3:0]  pg_wr_vpn;
  logic [2:0]  pg_wr_frame;
  logic        pg_wr_present;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_fault_vpn;

  int total = 0;
  int bad   = 0;
  bit chk_on = 0;
  bit done   = 0;

  seg_page_xlat u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
    .seg_wr_base(seg_wr_base), .seg_wr_limit(seg_wr_limit),
    .pg_wr_en(pg_wr_en), .pg_wr_vpn(pg_wr_vpn), .pg_wr_frame(pg_wr_frame),
    .pg_wr_present(pg_wr_present), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_vpn(rsp_fault_vpn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  int mbase [16];
  int mlim  [16];
  int mfrm  [16];
  int mpres [16];
  int m1v = 0, m1lin = 0, m1lf = 0;
  int m2v = 0, m2pa = 0, m2f = 0, m2pg = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mbase[i] = 0; mlim[i] = 0; mfrm[i] = 0; mpres[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m1v = 0; m2v = 0;
    end else begin
      m2v = m1v;
      if (m1v != 0) begin
        if (m1lf != 0) begin
          m2f = 1; m2pa = 0; m2pg = 0;
        end else if (mpres[m1lin / 4096] == 0) begin
          m2f = 2; m2pa = 0; m2pg = m1lin / 4096;
        end else begin
          m2f = 0; m2pg = 0;
          m2pa = mfrm[m1lin / 4096] * 4096 + (m1lin % 4096);
        end
      end
      m1v = req_valid ? 1 : 0;
      if (req_valid) begin
        if (int'(req_off) >= mlim[req_sel]) begin
          m1lf = 1; m1lin = 0;
        end else begin
          m1lf = 0; m1lin = (mbase[req_sel] + int'(req_off)) % 65536;
        end
      end
      if (seg_wr_en) begin
        mbase[seg_wr_idx] = int'(seg_wr_base);
        mlim[seg_wr_idx]  = int'(seg_wr_limit);
      end
      if (pg_wr_en) begin
        mfrm[pg_wr_vpn]  = int'(pg_wr_frame);
        mpres[pg_wr_vpn] = pg_wr_present ? 1 : 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      check("R2 model valid", int'(rsp_valid), m2v);
      if (m2v != 0) begin
        if (m2f == 1)      check("R4 model fault", int'(rsp_fault), m2f);
        else if (m2f == 2) check("R6 model fault", int'(rsp_fault), m2f);
        else               check("R5 model fault", int'(rsp_fault), m2f);
        check("R5 model paddr", int'(rsp_paddr), m2pa);
        check("R6 model vpn", int'(rsp_fault_vpn), m2pg);
      end
    end
  end

  task automatic seg_wr(input int idx, input int base, input int lim);
    seg_wr_en = 1; seg_wr_idx = 4'(idx); seg_wr_base = 16'(base); seg_wr_limit = 16'(lim);
    @(negedge clk);
    seg_wr_en = 0;
  endtask

  task automatic pg_wr(input int vpn, input int frm, input int pres);
    pg_wr_en = 1; pg_wr_vpn = 4'(vpn); pg_wr_frame = 3'(frm); pg_wr_present = 1'(pres);
    @(negedge clk);
    pg_wr_en = 0;
  endtask

  task automatic xlat(input string tag, input int sel, input int off,
                      input int efault, input int epa, input int evpn);
    req_valid = 1; req_sel = 4'(sel); req_off = 16'(off);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check({tag, " valid"}, int'(rsp_valid), 1);
    check({tag, " fault"}, int'(rsp_fault), efault);
    check({tag, " paddr"}, int'(rsp_paddr), epa);
    check({tag, " vpn"}, int'(rsp_fault_vpn), evpn);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_sel = 0; req_off = 0;
    seg_wr_en = 0; seg_wr_idx = 0; seg_wr_base = 0; seg_wr_limit = 0;
    pg_wr_en = 0; pg_wr_vpn = 0; pg_wr_frame = 0; pg_wr_present = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset valid low", int'(rsp_valid), 0);
    chk_on = 1;

    xlat("R1 empty tables", 0, 0, 1, 0, 0);
    xlat("R1 empty shared", 8, 5, 1, 0, 0);

    seg_wr(2, 16'h2000, 16'h1000);
    seg_wr(10, 16'h5000, 16'h0800);
    seg_wr(3, 16'h8000, 16'h0100);
    seg_wr(4, 16'hF000, 16'h2000);
    pg_wr(2, 6, 1);
    pg_wr(5, 3, 1);
    pg_wr(0, 2, 1);

    xlat("R3 R5 private", 2, 16'h0004, 0, 16'h6004, 0);
    xlat("R3 shared", 10, 16'h0014, 0, 16'h3014, 0);
    xlat("R4 last byte", 2, 16'h0FFF, 0, 16'h6FFF, 0);
    xlat("R4 at length", 2, 16'h1000, 1, 0, 0);
    xlat("R3 shared length", 10, 16'h0800, 1, 0, 0);
    xlat("R6 absent page", 3, 16'h000C, 2, 0, 8);
    xlat("R7 priority", 3, 16'h0100, 1, 0, 0);
    xlat("R5 wrap", 4, 16'h1004, 0, 16'h2004, 0);

    // R8: descriptor write on the same edge as the lookup
    seg_wr_en = 1; seg_wr_idx = 4'd5; seg_wr_base = 16'h0000; seg_wr_limit = 16'h0100;
    req_valid = 1; req_sel = 4'd5; req_off = 16'h0010;
    @(negedge clk);
    seg_wr_en = 0; req_valid = 0;
    @(negedge clk);
    check("R8 seg old entry", int'(rsp_fault), 1);
    xlat("R8 seg new entry", 5, 16'h0010, 0, 16'h2010, 0);

    // R8: page write on the edge where stage two looks up
    req_valid = 1; req_sel = 4'd3; req_off = 16'h000C;
    @(negedge clk);
    req_valid = 0;
    pg_wr_en = 1; pg_wr_vpn = 4'd8; pg_wr_frame = 3'd1; pg_wr_present = 1;
    @(negedge clk);
    pg_wr_en = 0;
    check("R8 page old entry", int'(rsp_fault), 2);
    xlat("R8 page new entry", 3, 16'h000C, 0, 16'h100C, 0);

    // random stream, checked by the model each cycle
    for (int c = 0; c < 600; c++) begin
      req_valid = 1'($urandom_range(0, 1));
      req_sel   = 4'($urandom_range(0, 15));
      req_off   = 16'($urandom_range(0, 16'h1400));
      seg_wr_en = ($urandom_range(0, 9) == 0);
      seg_wr_idx = 4'($urandom_range(0, 15));
      seg_wr_base = 16'($urandom_range(0, 16'hFFFF));
      seg_wr_limit = 16'($urandom_range(0, 16'h1400));
      pg_wr_en = ($urandom_range(0, 7) == 0);
      pg_wr_vpn = 4'($urandom_range(0, 15));
      pg_wr_frame = 3'($urandom_range(0, 7));
      pg_wr_present = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    req_valid = 0; seg_wr_en = 0; pg_wr_en = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule